// File: doc/BRIEF.md
# MESI Line State Controller

This block holds the four-state coherence status (Invalid, Shared, Exclusive, Modified) of every line in a small write-back data cache. It updates that status in response to local processor traffic. A line-fill completion strobe installs a freshly loaded line. The state it installs comes from an external write-back hint, and a per-page write-through attribute can override that hint. Read and write accesses arrive on a valid/ready request channel together with the tag lookup result. A write that must reach memory launches a one-cycle external write request and holds the channel until the bus acknowledges it.

A global flush walks the lines in ascending index order and returns every one of them to Invalid. A Modified line is not cleared until its copy-back has been handed off on a second valid/ready channel. A combinational query port reports the state of any line and whether it is dirty.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while an external write is outstanding and while a flush is pending or running. On the copy-back channel, `cb_valid` and `cb_idx` stay constant until `cb_ready` is seen high at a clock edge.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 2'b00), `req_ready` is 1, and `wr_req`, `cb_valid` and `flush_busy` are 0.
- R2: A fill with `fill_wb_hint`=1 and `fill_page_wt`=0 leaves the line Exclusive (code 2'b10) on the next cycle.
- R3: A fill with `fill_wb_hint`=0, or with `fill_page_wt`=1 whatever the hint, leaves the line Shared (code 2'b01).
- R4: An accepted write with `req_hit`=1 to an Exclusive line makes it Modified (code 2'b11) and produces no `wr_req`.
- R5: An accepted write with `req_hit`=1 to a Shared line keeps it Shared, pulses `wr_req` with `wr_idx` equal to the request index, and holds `req_ready` low until `wr_ack` has been seen.
- R6: A write hit to a Modified line and a read hit to any valid line change no state and produce no `wr_req`.
- R7: A write with `req_hit`=0, or one addressed to an Invalid line, allocates nothing and leaves the line unchanged, and it issues `wr_req`. A read miss changes nothing.
- R8: `wr_req` is high for exactly one cycle, in the cycle after the request is accepted. `wr_ack` is only taken from the following cycle onward.
- R9: `qry_state` reports the state of line `qry_idx`, and `qry_dirty` is 1 exactly when that line is Modified.
- R10: A flush raises `flush_busy` and visits the lines in ascending order. For each Modified line it presents `cb_valid` with `cb_idx` and holds both until `cb_ready`. When `flush_busy` falls, every line is Invalid.
- R11: While `flush_busy` is high, `req_ready` is 0 and `fill_done` has no effect.
- R12: When a fill and an accepted access land in the same cycle, both take effect if they name different lines. If they name the same line, the fill result wins.
- R13: A flush requested while an external write is outstanding stays pending, with `flush_busy` high, and starts after `wr_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hit | input | 1 | Tag lookup hit for the request |
| req_idx | input | IDX_W | Line index of the request |
| fill_done | input | 1 | Line fill completed this cycle |
| fill_idx | input | IDX_W | Line index of the fill |
| fill_wb_hint | input | 1 | External write-back hint sampled for the fill |
| fill_page_wt | input | 1 | Page write-through attribute of the fill |
| wr_req | output | 1 | One-cycle external write request |
| wr_idx | output | IDX_W | Line index of the external write |
| wr_ack | input | 1 | External write completed |
| flush_req | input | 1 | Start a global flush |
| flush_busy | output | 1 | Flush pending or in progress |
| cb_valid | output | 1 | Copy-back of a Modified line requested |
| cb_idx | output | IDX_W | Line index to copy back |
| cb_ready | input | 1 | Copy-back accepted |
| qry_idx | input | IDX_W | Line index to inspect |
| qry_state | output | 2 | State of the inspected line |
| qry_dirty | output | 1 | Inspected line is Modified |

## Verification
A fill completion and an accepted access can fall in the same clock cycle. The bench drives both in one cycle with the request channel ready. It does this once with different line indices, where it expects the access outcome on one line and the fill outcome on the other. It does it again with the same index, where the fill result must be the one that remains. The other overlap is a flush request arriving while an external write waits for its acknowledge. The bench judges this case by requiring that `flush_busy` rises at once, that no copy-back starts and no line changes before `wr_ack`, and that the walk then finishes with every line Invalid.

// File: rtl/mesi_line_pkg.sv
package mesi_line_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    MD_IDLE,
    MD_WREQ,
    MD_WACK,
    MD_FLUSH
  } ctl_md_e;
endpackage

// File: rtl/mesi_fill_pick.sv
module mesi_fill_pick
  import mesi_line_pkg::*;
(
  input  logic     wb_hint,
  input  logic     page_wt,
  output line_st_e fill_st
);
  // page write-through overrides the bus hint and forces Shared
  always_comb begin
    if (wb_hint && !page_wt) fill_st = ST_E;
    else                     fill_st = ST_S;
  end
endmodule

// File: rtl/mesi_access_eval.sv
module mesi_access_eval
  import mesi_line_pkg::*;
(
  input  line_st_e cur_st,
  input  logic     is_write,
  input  logic     tag_hit,
  output line_st_e nxt_st,
  output logic     need_bus
);
  logic real_hit;

  assign real_hit = tag_hit && (cur_st != ST_I);

  always_comb begin
    nxt_st   = cur_st;
    need_bus = 1'b0;
    if (is_write) begin
      if (!real_hit) begin
        need_bus = 1'b1;          // no write-allocate
      end else begin
        unique case (cur_st)
          ST_E:    nxt_st   = ST_M;
          ST_S:    need_bus = 1'b1;
          default: nxt_st   = cur_st;
        endcase
      end
    end
  end
endmodule

// File: rtl/mesi_flush_walk.sv
module mesi_flush_walk
  import mesi_line_pkg::*;
#(
  parameter int LINES = 16,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  line_st_e         cur_st,
  input  logic             cb_ready,
  output logic [IDX_W-1:0] ptr,
  output logic             cb_valid,
  output logic             clr_en,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (start)  ptr_q <= '0;
    else if (clr_en) ptr_q <= ptr_q + 1'b1;
  end

  assign ptr      = ptr_q;
  assign cb_valid = active && (cur_st == ST_M);
  assign clr_en   = active && ((cur_st != ST_M) || cb_ready);
  assign last     = clr_en && (ptr_q == LAST_IDX);

  // R10
  cb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cb_valid && !cb_ready) |=> (cb_valid && $stable(ptr_q)));
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_line_pkg::*;
#(
  parameter int LINES = 16,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_hit,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             fill_done,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_wb_hint,
  input  logic             fill_page_wt,
  output logic             wr_req,
  output logic [IDX_W-1:0] wr_idx,
  input  logic             wr_ack,
  input  logic             flush_req,
  output logic             flush_busy,
  output logic             cb_valid,
  output logic [IDX_W-1:0] cb_idx,
  input  logic             cb_ready,
  input  logic [IDX_W-1:0] qry_idx,
  output logic [1:0]       qry_state,
  output logic             qry_dirty
);
  logic [LINES-1:0][1:0] st_q;
  ctl_md_e               md_q, md_d;
  logic                  pend_q;
  logic [IDX_W-1:0]      wr_idx_q;

  logic       acc, fill_en, need_bus, walk_start, walk_active;
  logic       clr_en, walk_last;
  logic [IDX_W-1:0] walk_ptr;
  line_st_e   cur_acc, nxt_acc, fill_st, cur_fl;

  assign req_ready   = (md_q == MD_IDLE) && !pend_q;
  assign flush_busy  = pend_q || (md_q == MD_FLUSH);
  assign acc         = req_valid && req_ready;
  assign fill_en     = fill_done && !flush_busy;
  assign walk_start  = (md_q == MD_IDLE) && pend_q;
  assign walk_active = (md_q == MD_FLUSH);
  assign cur_acc     = line_st_e'(st_q[req_idx]);
  assign cur_fl      = line_st_e'(st_q[walk_ptr]);

  mesi_fill_pick u_fill (
    .wb_hint (fill_wb_hint),
    .page_wt (fill_page_wt),
    .fill_st (fill_st)
  );

  mesi_access_eval u_eval (
    .cur_st   (cur_acc),
    .is_write (req_write),
    .tag_hit  (req_hit),
    .nxt_st   (nxt_acc),
    .need_bus (need_bus)
  );

  mesi_flush_walk #(.LINES(LINES), .IDX_W(IDX_W)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (walk_start),
    .active   (walk_active),
    .cur_st   (cur_fl),
    .cb_ready (cb_ready),
    .ptr      (walk_ptr),
    .cb_valid (cb_valid),
    .clr_en   (clr_en),
    .last     (walk_last)
  );

  // per-line state: flush clear > fill > access
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)
        st_q[i] <= ST_I;
      else if (clr_en && (walk_ptr == IDX_W'(i)))
        st_q[i] <= ST_I;
      else if (fill_en && (fill_idx == IDX_W'(i)))
        st_q[i] <= fill_st;
      else if (acc && (req_idx == IDX_W'(i)))
        st_q[i] <= nxt_acc;
    end
  end

  always_comb begin
    md_d = md_q;
    unique case (md_q)
      MD_IDLE: begin
        if (pend_q)               md_d = MD_FLUSH;
        else if (acc && need_bus) md_d = MD_WREQ;
      end
      MD_WREQ:  md_d = MD_WACK;
      MD_WACK:  if (wr_ack)    md_d = MD_IDLE;
      MD_FLUSH: if (walk_last) md_d = MD_IDLE;
      default:  md_d = MD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      md_q     <= MD_IDLE;
      pend_q   <= 1'b0;
      wr_idx_q <= '0;
    end else begin
      md_q   <= md_d;
      pend_q <= flush_req || (pend_q && !walk_start);
      if (acc && need_bus) wr_idx_q <= req_idx;
    end
  end

  assign wr_req    = (md_q == MD_WREQ);
  assign wr_idx    = wr_idx_q;
  assign cb_idx    = walk_ptr;
  assign qry_state = st_q[qry_idx];
  assign qry_dirty = (st_q[qry_idx] == ST_M);

  // R8
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);

  // R11
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !req_ready);

  // R3
  fill_wt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && fill_page_wt) |=> (st_q[$past(fill_idx)] == ST_S));

  // R4
  e_to_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_hit && (cur_acc == ST_E) &&
     !(fill_en && (fill_idx == req_idx)))
    |=> (st_q[$past(req_idx)] == ST_M) && !wr_req);

  // R12
  fill_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && acc && (fill_idx == req_idx))
    |=> (st_q[$past(fill_idx)] == $past(fill_st)));

  // R10
  flush_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_busy) |-> (st_q == '0));
endmodule

// File: tb/mesi_line_ctrl_tb_top.sv
module mesi_line_ctrl_tb_top;
  localparam int CLK_PER = 10;
  localparam int LN      = 16;
  localparam int IW      = $clog2(LN);
  localparam int WD_CYC  = 150000;
  localparam logic [1:0] SI = 2'b00, SS = 2'b01, SE = 2'b10, SM = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_hit = 0;
  logic [IW-1:0] req_idx = '0;
  logic req_ready;
  logic fill_done = 0, fill_wb_hint = 0, fill_page_wt = 0;
  logic [IW-1:0] fill_idx = '0;
  logic wr_req, wr_ack = 0;
  logic [IW-1:0] wr_idx;
  logic flush_req = 0, flush_busy;
  logic cb_valid, cb_ready = 0;
  logic [IW-1:0] cb_idx;
  logic [IW-1:0] qry_idx = '0;
  logic [1:0] qry_state;
  logic qry_dirty;

  int total = 0, bad = 0;
  logic [1:0] mdl [LN];

  always #(CLK_PER/2) clk = ~clk;

  mesi_line_ctrl #(.LINES(LN)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_hit(req_hit), .req_idx(req_idx),
    .fill_done(fill_done), .fill_idx(fill_idx), .fill_wb_hint(fill_wb_hint),
    .fill_page_wt(fill_page_wt),
    .wr_req(wr_req), .wr_idx(wr_idx), .wr_ack(wr_ack),
    .flush_req(flush_req), .flush_busy(flush_busy),
    .cb_valid(cb_valid), .cb_idx(cb_idx), .cb_ready(cb_ready),
    .qry_idx(qry_idx), .qry_state(qry_state), .qry_dirty(qry_dirty)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fill(input bit wb, input bit wt);
    return (wb && !wt) ? SE : SS;
  endfunction

  task automatic chk_line(input int idx, input string tag);
    qry_idx = IW'(idx);
    #1;
    chk(qry_state == mdl[idx], tag, int'(qry_state), int'(mdl[idx]));
    chk(qry_dirty == (mdl[idx] == SM), {tag, " R9"}, int'(qry_dirty), int'(mdl[idx] == SM));
  endtask

  task automatic chk_all(input string tag);
    for (int i = 0; i < LN; i++) chk_line(i, tag);
  endtask

  task automatic do_fill(input int idx, input bit wb, input bit wt, input string tag);
    @(negedge clk);
    fill_done = 1; fill_idx = IW'(idx); fill_wb_hint = wb; fill_page_wt = wt;
    if (!flush_busy) mdl[idx] = exp_fill(wb, wt);
    @(negedge clk);
    fill_done = 0;
    chk_line(idx, tag);
  endtask

  task automatic do_acc(input bit w, input bit h, input int idx);
    logic [1:0] cur, nx;
    bit bus, rhit;
    string tag;
    @(negedge clk);
    req_valid = 1; req_write = w; req_hit = h; req_idx = IW'(idx);
    while (!req_ready) @(negedge clk);
    cur = mdl[idx]; nx = cur; bus = 0;
    rhit = h && (cur != SI);
    if (!w) tag = rhit ? "R6" : "R7";
    else if (!rhit) begin bus = 1; tag = "R7"; end
    else if (cur == SE) begin nx = SM; tag = "R4"; end
    else if (cur == SS) begin bus = 1; tag = "R5"; end
    else tag = "R6";
    @(negedge clk);
    req_valid = 0;
    mdl[idx] = nx;
    if (bus) begin
      chk(wr_req == 1'b1, {tag, " R8 pulse"}, int'(wr_req), 1);
      chk(wr_idx == IW'(idx), {tag, " wr_idx"}, int'(wr_idx), idx);
      chk(req_ready == 1'b0, "R5 ready held", int'(req_ready), 0);
      @(negedge clk);
      chk(wr_req == 1'b0, "R8 one cycle", int'(wr_req), 0);
      repeat ($urandom % 3) begin
        chk(req_ready == 1'b0, "R5 wait ack", int'(req_ready), 0);
        @(negedge clk);
      end
      wr_ack = 1;
      @(negedge clk);
      wr_ack = 0;
      chk(req_ready == 1'b1, "R5 ready after ack", int'(req_ready), 1);
    end else begin
      chk(wr_req == 1'b0, {tag, " no bus"}, int'(wr_req), 0);
      chk(req_ready == 1'b1, {tag, " ready"}, int'(req_ready), 1);
    end
    chk_line(idx, tag);
  endtask

  task automatic run_flush(input bit send_req, input bit inject);
    int mlist [LN];
    int mc = 0, hs = 0, it = 0;
    bit r;
    for (int i = 0; i < LN; i++) if (mdl[i] == SM) begin mlist[mc] = i; mc++; end
    if (send_req) begin
      @(negedge clk); flush_req = 1;
      @(negedge clk); flush_req = 0;
    end
    chk(flush_busy == 1'b1, "R10 busy", int'(flush_busy), 1);
    while (flush_busy && it < 4000) begin
      chk(req_ready == 1'b0, "R11 ready low", int'(req_ready), 0);
      if (cb_valid) begin
        if (hs < mc) chk(cb_idx == IW'(mlist[hs]), "R10 order", int'(cb_idx), mlist[hs]);
        else chk(1'b0, "R10 extra copy-back", int'(cb_idx), -1);
      end
      if (inject && it == 1) begin
        fill_done = 1; fill_idx = IW'(3); fill_wb_hint = 1; fill_page_wt = 0;
      end else fill_done = 0;
      r = 1'($urandom % 2);
      cb_ready = r;
      if (cb_valid && r) hs++;
      @(negedge clk);
      it++;
    end
    cb_ready = 0; fill_done = 0;
    chk(hs == mc, "R10 copy-back count", hs, mc);
    for (int i = 0; i < LN; i++) mdl[i] = SI;
    chk_all(inject ? "R11 fill ignored" : "R10 all invalid");
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] cur;
    void'($urandom(32'd7351));
    for (int i = 0; i < LN; i++) mdl[i] = SI;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    chk(wr_req == 1'b0, "R1 wr_req", int'(wr_req), 0);
    chk(cb_valid == 1'b0, "R1 cb_valid", int'(cb_valid), 0);
    chk(flush_busy == 1'b0, "R1 busy", int'(flush_busy), 0);
    chk_all("R1 reset state");

    do_fill(0, 1, 0, "R2");
    do_fill(1, 0, 0, "R3");
    do_fill(2, 1, 1, "R3 override");
    do_fill(4, 0, 1, "R3");
    do_acc(0, 1, 0);          // R6 read hit on E
    do_acc(1, 1, 0);          // R4 E->M
    do_acc(1, 1, 0);          // R6 M stays
    do_acc(1, 1, 1);          // R5 S write
    do_acc(1, 0, 6);          // R7 write miss
    do_acc(1, 1, 7);          // R7 hit flag on Invalid line
    do_acc(0, 0, 8);          // R7 read miss

    // R12 different lines: fill 9, write hit on 0 (M, no bus)
    @(negedge clk);
    req_valid = 1; req_write = 1; req_hit = 1; req_idx = IW'(0);
    fill_done = 1; fill_idx = IW'(9); fill_wb_hint = 1; fill_page_wt = 0;
    chk(req_ready == 1'b1, "R12 ready", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 0; fill_done = 0;
    mdl[9] = SE;
    chk_line(0, "R12 access line");
    chk_line(9, "R12 fill line");
    // R12 same line: fill wins over access
    @(negedge clk);
    req_valid = 1; req_write = 1; req_hit = 1; req_idx = IW'(0);
    fill_done = 1; fill_idx = IW'(0); fill_wb_hint = 0; fill_page_wt = 0;
    @(negedge clk);
    req_valid = 0; fill_done = 0;
    mdl[0] = SS;
    chk(wr_req == 1'b0, "R12 no bus", int'(wr_req), 0);
    chk_line(0, "R12 fill wins");

    do_fill(10, 1, 0, "R2");
    do_acc(1, 1, 10);
    do_fill(12, 1, 0, "R2");
    do_acc(1, 1, 12);
    run_flush(1, 1);          // R10, R11

    // R13 flush during outstanding write
    do_fill(5, 0, 0, "R3");
    do_fill(11, 1, 0, "R2");
    do_acc(1, 1, 11);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_hit = 1; req_idx = IW'(5);
    @(negedge clk);
    req_valid = 0;
    chk(wr_req == 1'b1, "R13 write issued", int'(wr_req), 1);
    flush_req = 1;
    @(negedge clk);
    flush_req = 0;
    for (int k = 0; k < 3; k++) begin
      chk(flush_busy == 1'b1, "R13 pending busy", int'(flush_busy), 1);
      chk(cb_valid == 1'b0, "R13 no early copy-back", int'(cb_valid), 0);
      @(negedge clk);
    end
    chk_line(11, "R13 untouched before ack");
    wr_ack = 1;
    @(negedge clk);
    wr_ack = 0;
    run_flush(0, 0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op, idx;
      bit h;
      op = $urandom % 10;
      idx = $urandom % LN;
      cur = mdl[idx];
      h = (cur != SI) ? ($urandom % 8 != 0) : ($urandom % 4 == 0);
      if (n % 80 == 79) run_flush(1, 0);
      else if (op < 3) do_fill(idx, 1'($urandom % 2), 1'($urandom % 4 == 0), "R2/R3 rnd");
      else if (op < 5) do_acc(0, h, idx);
      else do_acc(1, h, idx);
    end
    chk_all("R9 final");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule